// File: doc/BRIEF.md
# Circular Trace Log Buffer

The block is a circular trace memory. While capture is enabled it stores one 256-bit snapshot of core state on every clock. The write pointer advances after each store and wraps back to entry zero. A flag flips on every wrap, so a reader can tell one pass over the buffer from the next. The current write position goes out as a 32-bit word. The pointer sits in the low bits of that word, and a marker bit set to one sits just above the pointer field.

Two readers share the registered RAM output, and each reader receives 64-bit words.
- The host reader presents a byte-style address every cycle and receives the selected word three clocks later.
- The debug reader works through an internal address register. A load pulse sets this register and starts a read. When a level-style data read by the debug side ends, the low part of the address advances by one word and the next read is issued automatically, so a debugger can stream the buffer out one word per access.

Bit 31 of either reader's address freezes capture. This lets the contents be inspected without being overwritten.

Top module: `trace_log_buf`

## Requirements
- R1: Capture is enabled on a clock edge only when `host_addr_i[31]` and `dbg_addr_o[31]` are both 0. While capture is disabled, the write pointer, the wrap flag and the stored entries all keep their values.
- R2: On an enabled edge, `cap_data_i` is stored at the write pointer and the pointer increments, wrapping from LOG_LENGTH-1 to 0.
- R3: `wrap_flag_o` inverts on each enabled edge where the pointer moves from LOG_LENGTH-1 to 0.
- R4: `wr_addr_o` equals the write pointer in bits [IW-1:0], with bit IW set to 1 and bits above IW at 0, where IW = log2(LOG_LENGTH).
- R5: Address fields for both readers:
  - Bits [IW+1:2] of an address select the entry.
  - Bits [1:0] select word n, which is entry bits [64n+63:64n].
  - For the host reader, if `host_addr_i` is held for three edges, `host_data_o` shows that word after the third edge.
- R6: A `dbg_load_i` pulse sampled at edge k loads `dbg_addr_i` into `dbg_addr_o` at edge k. `dbg_data_o` keeps its old value through edge k+2. At edge k+3 it takes the word addressed by `dbg_addr_o`, including that address's word-select bits.
- R7: End of a debug data read, and the automatic reissue:
  - The end is detected on the edge after `dbg_read_i` is first sampled low following a high sample.
  - On that edge, bits [IW+1:0] of `dbg_addr_o` increment, wrapping within that field, and the bits above stay unchanged.
  - A new debug read is issued with the same three-edge latency as R6.
  - A load pulse on that same edge takes priority over the increment.
- R8: After reset, `wr_addr_o` equals 1<<IW, and `wrap_flag_o`, `dbg_addr_o`, `dbg_data_o` and `host_data_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cap_data_i | input | 256 | Snapshot to record |
| host_addr_i | input | 32 | Host reader address; bit 31 freezes capture |
| host_data_o | output | 64 | Host reader word |
| dbg_load_i | input | 1 | Load debug address and issue a read |
| dbg_addr_i | input | 32 | Value loaded by `dbg_load_i` |
| dbg_read_i | input | 1 | Debug data read in progress (level) |
| dbg_addr_o | output | 32 | Current debug address; bit 31 freezes capture |
| dbg_data_o | output | 64 | Debug reader word |
| wr_addr_o | output | 32 | Write position with marker bit |
| wrap_flag_o | output | 1 | Flips on every pointer wrap |

## Verification
A corrupted write pointer shows up on `wr_addr_o` at the next clock. A missed or extra wrap shows up on `wrap_flag_o` in the same way. A broken freeze gate appears as a pointer that moves while bit 31 is set. It also appears three edges later as host words that differ from the contents captured before the freeze. A fault in the debug pipeline shows up as `dbg_data_o` changing one edge too early or too late. A fault in the auto-increment shows up as a wrong `dbg_addr_o` on the edge after a read ends. The bench therefore compares every output on every cycle against a behavioural model.

// File: rtl/trace_log_pkg.sv
`timescale 1ns/1ps
package trace_log_pkg;
  localparam int ENTRY_W = 256;
  localparam int WORD_W  = 64;
  localparam int ADDR_W  = 32;

  // Returns 64-bit word number sel of a 256-bit entry.
  function automatic logic [WORD_W-1:0] pick_word(input logic [ENTRY_W-1:0] ent,
                                                  input logic [1:0] sel);
    logic [WORD_W-1:0] w;
    case (sel)
      2'd0:    w = ent[63:0];
      2'd1:    w = ent[127:64];
      2'd2:    w = ent[191:128];
      default: w = ent[255:192];
    endcase
    return w;
  endfunction
endpackage

// File: rtl/tlog_writer.sv
`timescale 1ns/1ps
module tlog_writer #(
  parameter int DEPTH = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic [IW-1:0] ptr_o,
  output logic          toggle_o
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [IW-1:0] ptr_q, ptr_d;
  logic          tog_q, tog_d;

  always_comb begin
    ptr_d = ptr_q;
    tog_d = tog_q;
    if (en_i) begin
      ptr_d = ptr_q + 1'b1;
      if (ptr_q == LAST) tog_d = ~tog_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      tog_q <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      tog_q <= tog_d;
    end
  end

  assign ptr_o    = ptr_q;
  assign toggle_o = tog_q;

  // R1: a frozen buffer keeps its position and flag
  a_r1_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(ptr_q) && $stable(tog_q)));
  // R2: an enabled edge moves the pointer by one
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (ptr_q == IW'($past(ptr_q) + 1'b1)));
  // R3: the flag flips exactly on wrap
  a_r3_wrap_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ptr_q == LAST) |=> (tog_q != $past(tog_q)));
endmodule

// File: rtl/tlog_ram.sv
`timescale 1ns/1ps
module tlog_ram #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 256,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [IW-1:0]    rd_idx_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rd_q;

  // Storage array: no reset, write port only.
  always_ff @(posedge clk_i) begin
    if (we_i) mem[wr_idx_i] <= wr_data_i;
  end

  // Registered read; returns the old contents on an index collision.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= mem[rd_idx_i];
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/tlog_dbg_port.sv
`timescale 1ns/1ps
module tlog_dbg_port #(
  parameter int IW = 5,
  localparam int AW = IW + 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [31:0] load_addr_i,
  input  logic        read_i,
  output logic [31:0] addr_o,
  output logic        issue_o,
  output logic        done_o
);
  logic [31:0] addr_q, addr_d;
  logic        issue_q, issue_d;
  logic        rd_q, rd_q1;
  logic        reading_q, done_q;
  logic        read_end;

  assign read_end = rd_q1 & ~rd_q;

  always_comb begin
    addr_d  = addr_q;
    issue_d = 1'b0;
    if (load_i) begin
      addr_d  = load_addr_i;
      issue_d = 1'b1;
    end else if (read_end) begin
      addr_d[AW-1:0] = addr_q[AW-1:0] + AW'(1);
      issue_d        = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q    <= '0;
      issue_q   <= 1'b0;
      rd_q      <= 1'b0;
      rd_q1     <= 1'b0;
      reading_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      addr_q    <= addr_d;
      issue_q   <= issue_d;
      rd_q      <= read_i;
      rd_q1     <= rd_q;
      reading_q <= issue_q;
      done_q    <= reading_q;
    end
  end

  assign addr_o  = addr_q;
  assign issue_o = issue_q;
  assign done_o  = done_q;

  // R7: end of a read advances the word address inside its field
  a_r7_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_end && !load_i) |=> (addr_q[AW-1:0] == AW'($past(addr_q[AW-1:0]) + 1'b1)
                               && addr_q[31:AW] == $past(addr_q[31:AW])));
  // R6: an issued read reaches completion two edges later
  a_r6_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_q |=> ##1 done_q);
  // R6: a load always issues a read
  a_r6_load_issues: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> issue_q);
endmodule

// File: rtl/trace_log_buf.sv
`timescale 1ns/1ps
module trace_log_buf
  import trace_log_pkg::*;
#(
  parameter int LOG_LENGTH = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [255:0] cap_data_i,
  input  logic [31:0]  host_addr_i,
  output logic [63:0]  host_data_o,
  input  logic         dbg_load_i,
  input  logic [31:0]  dbg_addr_i,
  input  logic         dbg_read_i,
  output logic [31:0]  dbg_addr_o,
  output logic [63:0]  dbg_data_o,
  output logic [31:0]  wr_addr_o,
  output logic         wrap_flag_o
);
  localparam int IW = $clog2(LOG_LENGTH);
  localparam int AW = IW + 2;

  logic [IW-1:0]      wr_ptr;
  logic               cap_en;
  logic [31:0]        dbg_addr;
  logic               dbg_issue, dbg_done;
  logic [IW-1:0]      rd_idx_q, rd_idx_d;
  logic [ENTRY_W-1:0] ram_q;
  logic [63:0]        host_q, host_d, dbg_q, dbg_d;
  logic               unused_host_bits;

  assign unused_host_bits = ^host_addr_i[30:AW];

  // Capture freezes while either reader sets its top address bit.
  assign cap_en = ~host_addr_i[31] & ~dbg_addr[31];

  tlog_writer #(.DEPTH(LOG_LENGTH)) u_writer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (cap_en),
    .ptr_o    (wr_ptr),
    .toggle_o (wrap_flag_o)
  );

  tlog_dbg_port #(.IW(IW)) u_dbg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (dbg_load_i),
    .load_addr_i (dbg_addr_i),
    .read_i      (dbg_read_i),
    .addr_o      (dbg_addr),
    .issue_o     (dbg_issue),
    .done_o      (dbg_done)
  );

  tlog_ram #(.DEPTH(LOG_LENGTH), .WIDTH(ENTRY_W)) u_ram (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cap_en),
    .wr_idx_i  (wr_ptr),
    .wr_data_i (cap_data_i),
    .rd_idx_i  (rd_idx_q),
    .rd_data_o (ram_q)
  );

  // Read index: a debug issue takes the port for one cycle.
  always_comb begin
    rd_idx_d = dbg_issue ? dbg_addr[AW-1:2] : host_addr_i[AW-1:2];
    host_d   = pick_word(ram_q, host_addr_i[1:0]);
    dbg_d    = dbg_done ? pick_word(ram_q, dbg_addr[1:0]) : dbg_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_idx_q <= '0;
      host_q   <= '0;
      dbg_q    <= '0;
    end else begin
      rd_idx_q <= rd_idx_d;
      host_q   <= host_d;
      dbg_q    <= dbg_d;
    end
  end

  assign host_data_o = host_q;
  assign dbg_data_o  = dbg_q;
  assign dbg_addr_o  = dbg_addr;
  assign wr_addr_o   = {{(31 - IW){1'b0}}, 1'b1, wr_ptr};

  // R6: the debug word only moves when a read completes
  a_r6_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbg_done |=> $stable(dbg_q));
  // R1: top bit of the debug address blocks capture
  a_r1_dbg_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_addr[31] |=> $stable(wr_addr_o));
  // R4: exported position tracks the writer
  a_r4_position: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_en |=> (wr_addr_o[IW-1:0] != $past(wr_addr_o[IW-1:0])));
endmodule

// File: tb/trace_log_buf_bench.sv
`timescale 1ns/1ps
module trace_log_buf_bench;
  localparam int L  = 16;
  localparam int IW = $clog2(L);
  localparam int AW = IW + 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] cap_data = '0;
  logic [31:0]  host_addr = '0;
  logic         dbg_load = 1'b0;
  logic [31:0]  dbg_addr_in = '0;
  logic         dbg_read = 1'b0;
  logic [63:0]  host_data, dbg_data;
  logic [31:0]  dbg_addr, wr_addr;
  logic         wrap_flag;

  int errors = 0;
  int checks = 0;
  int stamp  = 1;

  always #4 clk = ~clk;

  trace_log_buf #(.LOG_LENGTH(L)) u_trace_log_buf (
    .clk_i(clk), .rst_ni(rst_n), .cap_data_i(cap_data),
    .host_addr_i(host_addr), .host_data_o(host_data),
    .dbg_load_i(dbg_load), .dbg_addr_i(dbg_addr_in), .dbg_read_i(dbg_read),
    .dbg_addr_o(dbg_addr), .dbg_data_o(dbg_data),
    .wr_addr_o(wr_addr), .wrap_flag_o(wrap_flag)
  );

  // Behavioural reference model
  logic [255:0] m_mem [L];
  bit           m_val [L];
  int           m_ptr, m_ridx;
  bit           m_tog, m_ramq_v, m_host_v, m_dbg_v, m_reading, m_done, m_issue, m_rd0, m_rd1;
  logic [255:0] m_ramq;
  logic [63:0]  m_host, m_dbg;
  logic [31:0]  m_daddr;

  function automatic logic [63:0] word_of(logic [255:0] e, int n);
    return e[64*n +: 64];
  endfunction

  function automatic logic [255:0] pattern(int s);
    logic [255:0] v;
    for (int w = 0; w < 4; w++) v[64*w +: 64] = {32'(s), 32'h5A00 + 32'(w)};
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ptr = 0; m_ridx = 0; m_tog = 0; m_ramq = '0; m_ramq_v = 1;
      m_host = '0; m_host_v = 1; m_dbg = '0; m_dbg_v = 1;
      m_reading = 0; m_done = 0; m_issue = 0; m_rd0 = 0; m_rd1 = 0; m_daddr = '0;
      for (int i = 0; i < L; i++) m_val[i] = 0;
    end else begin
      bit we, ending;
      we = !host_addr[31] && !m_daddr[31];
      if (m_done) begin
        m_dbg = word_of(m_ramq, int'(m_daddr[1:0])); m_dbg_v = m_ramq_v;
      end
      m_host = word_of(m_ramq, int'(host_addr[1:0])); m_host_v = m_ramq_v;
      m_ramq = m_mem[m_ridx]; m_ramq_v = m_val[m_ridx];
      m_ridx = m_issue ? int'(m_daddr[AW-1:2]) : int'(host_addr[AW-1:2]);
      m_done = m_reading; m_reading = m_issue;
      if (we) begin
        m_mem[m_ptr] = cap_data; m_val[m_ptr] = 1;
        if (m_ptr == L - 1) m_tog = !m_tog;
        m_ptr = (m_ptr + 1) % L;
      end
      ending = m_rd1 && !m_rd0;
      if (dbg_load) begin m_daddr = dbg_addr_in; m_issue = 1; end
      else if (ending) begin m_daddr[AW-1:0] = m_daddr[AW-1:0] + 1'b1; m_issue = 1; end
      else m_issue = 0;
      m_rd1 = m_rd0; m_rd0 = dbg_read;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    if (m_host_v) chk("R5 host word", host_data, m_host);
    if (m_dbg_v)  chk("R6 debug word", dbg_data, m_dbg);
    chk("R4 write position", 64'(wr_addr), 64'((1 << IW) | m_ptr));
    chk("R3 wrap flag", 64'(wrap_flag), 64'(m_tog));
    chk("R7 debug address", 64'(dbg_addr), 64'(m_daddr));
  endtask

  // One clock edge, then compare at the falling edge and advance the snapshot.
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    stamp++;
    cap_data = pattern(stamp);
  endtask

  task automatic run_all();
    logic [31:0] p;
    logic [63:0] old;
    cap_data = pattern(stamp);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    chk("R8 reset position", 64'(wr_addr), 64'(1 << IW));
    chk("R8 reset wrap", 64'(wrap_flag), 64'd0);
    chk("R8 reset host data", host_data, 64'd0);
    chk("R8 reset debug data", dbg_data, 64'd0);
    chk("R8 reset debug address", 64'(dbg_addr), 64'd0);
    rst_n = 1'b1;
    // R2 and R3: fill past one wrap
    for (int i = 0; i < L + 3; i++) cyc();
    chk("R2 pointer after wrap", 64'(wr_addr), 64'((1 << IW) | 3));
    chk("R3 flag after wrap", 64'(wrap_flag), 64'd1);
    // R1: freeze through host bit 31
    p = wr_addr;
    host_addr = 32'h8000_0000 | (32'd5 << 2);
    for (int i = 0; i < 6; i++) cyc();
    chk("R1 host freeze", 64'(wr_addr), 64'(p));
    // R5: each of the four words of entry 5
    for (int s = 0; s < 4; s++) begin
      host_addr = 32'h8000_0000 | (32'd5 << 2) | 32'(s);
      for (int i = 0; i < 3; i++) cyc();
      chk("R5 word select", host_data, word_of(m_mem[5], s));
    end
    // R6: debug latency, entry 7 word 2
    old = dbg_data;
    dbg_addr_in = (32'd7 << 2) | 32'd2;
    dbg_load = 1'b1;
    cyc();
    dbg_load = 1'b0;
    cyc(); chk("R6 hold at k+1", dbg_data, old);
    cyc(); chk("R6 hold at k+2", dbg_data, old);
    cyc(); chk("R6 update at k+3", dbg_data, word_of(m_mem[7], 2));
    // R7: end of a read advances to word 3 and reissues
    dbg_read = 1'b1; cyc(); cyc();
    dbg_read = 1'b0; cyc();
    cyc(); chk("R7 increment", 64'(dbg_addr), 64'((7 << 2) | 3));
    cyc(); cyc(); cyc();
    chk("R7 reissued read", dbg_data, word_of(m_mem[7], 3));
    // R7: increment wraps inside the index field, upper bit kept
    dbg_addr_in = 32'h0000_0000 | (32'd1 << AW) | ((32'd1 << AW) - 1);
    dbg_load = 1'b1; cyc(); dbg_load = 1'b0;
    dbg_read = 1'b1; cyc(); dbg_read = 1'b0; cyc();
    cyc(); chk("R7 field wrap", 64'(dbg_addr), 64'(32'd1 << AW));
    cyc(); cyc(); cyc();
    chk("R7 wrapped read", dbg_data, word_of(m_mem[0], 0));
    // R1: freeze through debug bit 31
    host_addr = 32'd0;
    dbg_addr_in = 32'h8000_0000;
    dbg_load = 1'b1; cyc(); dbg_load = 1'b0;
    p = wr_addr;
    for (int i = 0; i < 5; i++) cyc();
    chk("R1 debug freeze", 64'(wr_addr), 64'(p));
    // Release and resume
    dbg_addr_in = 32'd0;
    dbg_load = 1'b1; cyc(); dbg_load = 1'b0;
    cyc(); cyc(); cyc();
    chk("R2 resume", 64'(wr_addr), 64'((1 << IW) | ((p[IW-1:0] + 3) % L)));
    for (int i = 0; i < 2 * L; i++) begin
      host_addr = 32'(i * 3);
      cyc();
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        #(8 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule